// File: doc/BRIEF.md
# LRU Fence Slot Allocator

This block hands out a small pool of fence slots to owners identified by a tag. Each slot carries a pin count, an optional owner binding, a dirty mark and a reserved mark, and all slots share an age order from oldest to newest. Requests arrive one at a time: pin a slot for an owner, unpin it, force-remove the owner's slot, mark the owner's slot dirty, reserve a slot for exclusive outside use, or hand a reserved slot back.

An owner that already holds a slot gets the same slot again. Otherwise the oldest slot with a zero pin count is taken. If that slot belonged to someone else, a one-cycle revoke event carries the old owner's tag, so its mapping can be torn down. Programming of the slot hardware is left outside: the block raises an update request with a ready/error handshake and waits for it before answering. Every request ends with exactly one response that carries a status code and a slot index.

Top module: `fence_lru_alloc`

## Requirements
- R1: After reset every slot is unpinned, unbound and unreserved, the age order is slot 0 oldest through slot NSLOT-1 newest, req_ready is 1, and resp_valid, revoke_valid and upd_valid are 0.
- R2: A pin (op 0) from an owner that holds no slot takes the unpinned, unreserved slot that is oldest, raises an update with upd_enable=1 carrying that slot and the owner, and after upd_ready with upd_err=0 answers status OK (0) with that slot, which becomes the newest.
- R3: A pin from an owner that already holds a clean slot raises its pin count, makes it the newest and answers OK with no update; a pin count already at its maximum answers BUSY (3) instead.
- R4: A pin of a slot marked dirty by op 5 reprograms it through the update port and clears the mark, so the next pin of it raises no update; op 5 from an owner with no slot answers NOENT (5).
- R5: Taking a slot bound to another owner emits revoke_valid for one cycle with that owner's tag, in the first cycle of the update request, and the old owner no longer holds the slot.
- R6: When no unpinned, unreserved slot exists a pin answers AGAIN (1) if flip_pending was high when the request was taken and DEADLOCK (2) otherwise, with no update and no change of state.
- R7: Force-removal (op 2) answers BUSY when the owner's slot is pinned; for an unpinned slot it revokes the owner, raises an update with upd_enable=0 and moves the slot to the oldest end; an owner with no slot gets OK at once with no update.
- R8: Reserve (op 3) answers NOSPC (4) when fewer than two unpinned, unreserved slots exist; otherwise it takes the oldest of them (clearing a bound owner through revoke and an update with upd_enable=0), answers OK with its index, and the slot is never chosen by a pin until released.
- R9: Unreserve (op 4) of the slot on req_slot puts it back at the oldest end and answers OK; for a slot not reserved it answers NOENT.
- R10: An update that ends with upd_err=1 answers FAULT (6) and gives back the pin taken for that request.
- R11: Unpin (op 1) lowers the owner's pin count and answers OK; with no held slot or a zero count it answers NOENT.
- R12: While upd_valid is high and upd_ready is low, upd_valid, upd_slot and upd_enable hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_op | input | 3 | 0 pin, 1 unpin, 2 remove, 3 reserve, 4 unreserve, 5 mark dirty |
| req_owner | input | OWN_W | Owner tag of the request |
| req_slot | input | $clog2(NSLOT) | Slot index for unreserve |
| flip_pending | input | 1 | A pending flip will free a slot later |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_status | output | 3 | 0 OK, 1 AGAIN, 2 DEADLOCK, 3 BUSY, 4 NOSPC, 5 NOENT, 6 FAULT |
| resp_slot | output | $clog2(NSLOT) | Slot granted or touched |
| revoke_valid | output | 1 | One-cycle revoke strobe |
| revoke_owner | output | OWN_W | Owner losing its slot |
| upd_valid | output | 1 | Slot programming request |
| upd_ready | input | 1 | Programming done this cycle |
| upd_err | input | 1 | Programming failed, valid with upd_ready |
| upd_enable | output | 1 | 1 program for owner, 0 clear slot |
| upd_slot | output | $clog2(NSLOT) | Slot to program |
| upd_owner | output | OWN_W | Owner to program the slot for |

## Verification
The bench walks a four-slot pool through a fixed history so that the victim is always known: it checks that a steal lands on the oldest unpinned slot rather than the lowest index, that a reserved slot is skipped by a later pin, and that an unreserved slot comes back as the oldest. A design that updated ages wrongly would hand out the wrong slot index; one that kept the pin after a failed update would skip the slot on the retry, and one that ignored flip_pending or counted reserved slots as free would return the wrong failure code. Re-pinning with and without the dirty mark shows whether reprogramming is skipped only for clean slots, and a delayed acknowledge shows the update request holding.

// File: rtl/fence_lru_alloc.sv
module fence_lru_alloc #(
  parameter int NSLOT = 16,
  parameter int OWN_W = 8,
  parameter int PIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [OWN_W-1:0] req_owner,
  input  logic [$clog2(NSLOT)-1:0] req_slot,
  input  logic             flip_pending,
  output logic             resp_valid,
  output logic [2:0]       resp_status,
  output logic [$clog2(NSLOT)-1:0] resp_slot,
  output logic             revoke_valid,
  output logic [OWN_W-1:0] revoke_owner,
  output logic             upd_valid,
  input  logic             upd_ready,
  input  logic             upd_err,
  output logic             upd_enable,
  output logic [$clog2(NSLOT)-1:0] upd_slot,
  output logic [OWN_W-1:0] upd_owner
);
  localparam int SW = $clog2(NSLOT);
  localparam int CW = $clog2(NSLOT + 1);
  localparam logic [PIN_W-1:0] PMAX = '1;
  localparam logic [SW-1:0] TOP = SW'(NSLOT - 1);

  localparam logic [2:0] OP_PIN = 3'd0, OP_UNPIN = 3'd1, OP_REMOVE = 3'd2,
                         OP_RSV = 3'd3, OP_UNRSV = 3'd4, OP_DIRTY = 3'd5;
  localparam logic [2:0] ST_OK = 3'd0, ST_AGAIN = 3'd1, ST_DEADLK = 3'd2,
                         ST_BUSY = 3'd3, ST_NOSPC = 3'd4, ST_NOENT = 3'd5,
                         ST_FAULT = 3'd6;

  logic [PIN_W-1:0] pin   [NSLOT];
  logic [OWN_W-1:0] owner [NSLOT];
  logic [SW-1:0]    age   [NSLOT];
  logic [NSLOT-1:0] bound, dirty, rsv;

  logic             busy, c_en;
  logic [2:0]       c_op;
  logic [SW-1:0]    c_slot;
  logic [OWN_W-1:0] c_owner;

  assign req_ready = !busy;
  assign upd_valid = busy;
  assign upd_enable = c_en;
  assign upd_slot = c_slot;
  assign upd_owner = c_owner;

  logic          hit, vic_ok;
  logic [SW-1:0] hit_idx, vic_idx, vic_age;
  logic [CW-1:0] free_cnt;

  always_comb begin
    hit = 1'b0; hit_idx = '0;
    vic_ok = 1'b0; vic_idx = '0; vic_age = '0;
    free_cnt = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (bound[i] && !rsv[i] && owner[i] == req_owner) begin
        hit = 1'b1;
        hit_idx = SW'(i);
      end
      if (pin[i] == '0 && !rsv[i]) begin
        free_cnt = free_cnt + 1'b1;
        if (!vic_ok || age[i] < vic_age) begin
          vic_ok = 1'b1;
          vic_idx = SW'(i);
          vic_age = age[i];
        end
      end
    end
  end

  logic [SW-1:0]    tgt, rsp_slot;
  logic [2:0]       sts;
  logic [OWN_W-1:0] rev_own;
  logic pin_up, pin_dn, bind_on, bind_off, dty_on, dty_off, rsv_on, rsv_off;
  logic mv, mv_top, go, go_en, done, rev;

  always_comb begin
    tgt = c_slot; rsp_slot = c_slot; sts = ST_OK; rev_own = '0;
    pin_up = 1'b0; pin_dn = 1'b0; bind_on = 1'b0; bind_off = 1'b0;
    dty_on = 1'b0; dty_off = 1'b0; rsv_on = 1'b0; rsv_off = 1'b0;
    mv = 1'b0; mv_top = 1'b0; go = 1'b0; go_en = 1'b0; done = 1'b0; rev = 1'b0;
    if (!busy && req_valid) begin
      case (req_op)
        OP_PIN: begin
          if (hit) begin
            tgt = hit_idx; rsp_slot = hit_idx;
            if (pin[hit_idx] == PMAX) begin
              done = 1'b1; sts = ST_BUSY;
            end else begin
              pin_up = 1'b1;
              if (dirty[hit_idx]) begin
                go = 1'b1; go_en = 1'b1;
              end else begin
                mv = 1'b1; mv_top = 1'b1; done = 1'b1;
              end
            end
          end else if (vic_ok) begin
            tgt = vic_idx; pin_up = 1'b1; go = 1'b1; go_en = 1'b1;
            if (bound[vic_idx]) begin
              rev = 1'b1; rev_own = owner[vic_idx]; bind_off = 1'b1;
            end
          end else begin
            done = 1'b1;
            sts = flip_pending ? ST_AGAIN : ST_DEADLK;
          end
        end
        OP_UNPIN: begin
          done = 1'b1;
          if (hit && pin[hit_idx] != '0) begin
            tgt = hit_idx; rsp_slot = hit_idx; pin_dn = 1'b1;
          end else sts = ST_NOENT;
        end
        OP_REMOVE: begin
          if (!hit) done = 1'b1;
          else begin
            tgt = hit_idx; rsp_slot = hit_idx;
            if (pin[hit_idx] != '0) begin
              done = 1'b1; sts = ST_BUSY;
            end else begin
              rev = 1'b1; rev_own = req_owner; bind_off = 1'b1; go = 1'b1;
            end
          end
        end
        OP_RSV: begin
          if (free_cnt < CW'(2)) begin
            done = 1'b1; sts = ST_NOSPC;
          end else begin
            tgt = vic_idx; rsp_slot = vic_idx;
            if (bound[vic_idx]) begin
              rev = 1'b1; rev_own = owner[vic_idx]; bind_off = 1'b1; go = 1'b1;
            end else begin
              rsv_on = 1'b1; done = 1'b1;
            end
          end
        end
        OP_UNRSV: begin
          done = 1'b1; tgt = req_slot; rsp_slot = req_slot;
          if (rsv[req_slot]) begin
            rsv_off = 1'b1; mv = 1'b1;
          end else sts = ST_NOENT;
        end
        OP_DIRTY: begin
          done = 1'b1;
          if (hit) begin
            tgt = hit_idx; rsp_slot = hit_idx; dty_on = 1'b1;
          end else sts = ST_NOENT;
        end
        default: begin
          done = 1'b1; sts = ST_NOENT;
        end
      endcase
    end else if (busy && upd_ready) begin
      done = 1'b1;
      if (upd_err) begin
        sts = ST_FAULT;
        pin_dn = (c_op == OP_PIN);
      end else begin
        case (c_op)
          OP_PIN:    begin bind_on = 1'b1; dty_off = 1'b1; mv = 1'b1; mv_top = 1'b1; end
          OP_REMOVE: mv = 1'b1;
          OP_RSV:    rsv_on = 1'b1;
          default:   ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; c_en <= 1'b0; c_op <= '0; c_slot <= '0; c_owner <= '0;
      resp_valid <= 1'b0; resp_status <= '0; resp_slot <= '0;
      revoke_valid <= 1'b0; revoke_owner <= '0;
      bound <= '0; dirty <= '0; rsv <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        pin[i] <= '0; owner[i] <= '0; age[i] <= SW'(i);
      end
    end else begin
      if (go) begin
        busy <= 1'b1; c_op <= req_op; c_slot <= tgt;
        c_owner <= req_owner; c_en <= go_en;
      end else if (busy && done) busy <= 1'b0;
      resp_valid <= done;
      resp_status <= sts;
      resp_slot <= rsp_slot;
      revoke_valid <= rev;
      revoke_owner <= rev_own;
      for (int i = 0; i < NSLOT; i++) begin
        if (SW'(i) == tgt) begin
          if (pin_up) pin[i] <= pin[i] + 1'b1;
          else if (pin_dn) pin[i] <= pin[i] - 1'b1;
          if (bind_on) begin
            bound[i] <= 1'b1; owner[i] <= c_owner;
          end else if (bind_off) bound[i] <= 1'b0;
          if (dty_on) dirty[i] <= 1'b1;
          else if (dty_off) dirty[i] <= 1'b0;
          if (rsv_on) rsv[i] <= 1'b1;
          else if (rsv_off) rsv[i] <= 1'b0;
        end
        if (mv) begin
          if (SW'(i) == tgt) age[i] <= mv_top ? TOP : '0;
          else if (mv_top && age[i] > age[tgt]) age[i] <= age[i] - 1'b1;
          else if (!mv_top && age[i] < age[tgt]) age[i] <= age[i] + 1'b1;
        end
      end
    end
  end

  logic [NSLOT-1:0] age_mask;
  logic             rsv_bad;
  always_comb begin
    age_mask = '0;
    rsv_bad = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      age_mask[age[i]] = 1'b1;
      if (rsv[i] && (pin[i] != '0 || bound[i])) rsv_bad = 1'b1;
    end
  end

  assert_age_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    age_mask == '1);

  assert_revoke_with_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
    revoke_valid |-> upd_valid);

  assert_again_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_status == ST_AGAIN) |-> $past(flip_pending));

  assert_deadlock_noflip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_status == ST_DEADLK) |-> !$past(flip_pending));

  assert_nospc_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_status == ST_NOSPC) |-> free_cnt < CW'(2));

  assert_reserved_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsv_bad);

  assert_upd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_ready) |=> (upd_valid && $stable(upd_slot) && $stable(upd_enable)));
endmodule

// File: tb/fence_lru_alloc_bench.sv
module fence_lru_alloc_bench;
  localparam int CLK_P = 10;
  localparam int N = 4;
  localparam int SW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, flip_pending = 1'b0, upd_ready = 1'b0, upd_err = 1'b0;
  logic [2:0] req_op = '0;
  logic [7:0] req_owner = '0;
  logic [SW-1:0] req_slot = '0;
  logic req_ready, resp_valid, revoke_valid, upd_valid, upd_enable;
  logic [2:0] resp_status;
  logic [SW-1:0] resp_slot, upd_slot;
  logic [7:0] revoke_owner, upd_owner;

  fence_lru_alloc #(.NSLOT(N), .OWN_W(8), .PIN_W(4)) u_fence_lru_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_owner(req_owner), .req_slot(req_slot),
    .flip_pending(flip_pending), .resp_valid(resp_valid), .resp_status(resp_status),
    .resp_slot(resp_slot), .revoke_valid(revoke_valid), .revoke_owner(revoke_owner),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_err(upd_err),
    .upd_enable(upd_enable), .upd_slot(upd_slot), .upd_owner(upd_owner));

  always #(CLK_P / 2) clk = ~clk;

  int checks = 0, fails = 0;
  logic finished = 1'b0;

  logic [2:0] r_sts;
  logic [SW-1:0] r_slot, g_uslot;
  logic g_upd, g_en, g_rev, g_hold_ok;
  logic [7:0] g_uown, g_rown;
  logic ack_err = 1'b0;
  int ack_wait = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [2:0] op, input logic [7:0] own, input logic [SW-1:0] sl);
    int n, held;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_owner = own; req_slot = sl;
    @(negedge clk);
    req_valid = 1'b0;
    g_upd = 1'b0; g_rev = 1'b0; g_hold_ok = 1'b1; g_en = 1'b0;
    g_uslot = '0; g_uown = '0; g_rown = '0;
    n = 0; held = 0;
    while (!resp_valid && n < 50) begin
      if (revoke_valid) begin g_rev = 1'b1; g_rown = revoke_owner; end
      if (upd_valid) begin
        if (g_upd && (upd_slot != g_uslot || upd_enable != g_en)) g_hold_ok = 1'b0;
        g_upd = 1'b1; g_en = upd_enable; g_uslot = upd_slot; g_uown = upd_owner;
        if (held < ack_wait) held++;
        else begin upd_ready = 1'b1; upd_err = ack_err; end
      end
      @(negedge clk);
      upd_ready = 1'b0; upd_err = 1'b0;
      n++;
    end
    chk(resp_valid, "handshake", int'(resp_valid), 1);
    r_sts = resp_status; r_slot = resp_slot;
  endtask

  task automatic t_reset;
    chk(req_ready, "R1 ready", int'(req_ready), 1);
    chk(!resp_valid && !revoke_valid && !upd_valid, "R1 idle outputs",
        int'({resp_valid, revoke_valid, upd_valid}), 0);
  endtask

  task automatic t_first_pins;
    do_req(3'd0, 8'h11, '0);
    chk(g_upd && g_en && g_uslot == 0 && g_uown == 8'h11, "R2 update for slot0",
        int'(g_uslot), 0);
    chk(!g_rev, "R2 no revoke on free slot", int'(g_rev), 0);
    chk(r_sts == 0 && r_slot == 0, "R2 pin A", int'(r_slot), 0);
    do_req(3'd0, 8'h22, '0);
    chk(r_sts == 0 && r_slot == 1, "R2 pin B oldest slot1", int'(r_slot), 1);
  endtask

  task automatic t_hit_unpin;
    do_req(3'd0, 8'h11, '0);
    chk(!g_upd && r_sts == 0 && r_slot == 0, "R3 clean hit no update", int'(g_upd), 0);
    do_req(3'd1, 8'h11, '0);
    chk(r_sts == 0, "R11 unpin 1", int'(r_sts), 0);
    do_req(3'd1, 8'h11, '0);
    chk(r_sts == 0, "R11 unpin 2", int'(r_sts), 0);
    do_req(3'd1, 8'h11, '0);
    chk(r_sts == 5, "R11 unpin at zero", int'(r_sts), 5);
  endtask

  task automatic t_dirty;
    do_req(3'd5, 8'h11, '0);
    chk(r_sts == 0, "R4 mark dirty", int'(r_sts), 0);
    do_req(3'd0, 8'h11, '0);
    chk(g_upd && g_en && g_uslot == 0 && r_sts == 0 && r_slot == 0, "R4 dirty reprogram",
        int'(g_upd), 1);
    do_req(3'd0, 8'h11, '0);
    chk(!g_upd && r_slot == 0, "R4 dirty cleared", int'(g_upd), 0);
    do_req(3'd5, 8'h99, '0);
    chk(r_sts == 5, "R4 dirty no slot", int'(r_sts), 5);
    do_req(3'd1, 8'h11, '0);
    do_req(3'd1, 8'h11, '0);
  endtask

  task automatic t_steal;
    do_req(3'd0, 8'h33, '0);
    chk(r_slot == 2 && !g_rev, "R2 pin C slot2", int'(r_slot), 2);
    do_req(3'd0, 8'h44, '0);
    chk(r_slot == 3 && !g_rev, "R2 pin D slot3", int'(r_slot), 3);
    do_req(3'd0, 8'h55, '0);
    chk(g_rev && g_rown == 8'h11, "R5 revoke previous owner", int'(g_rown), 8'h11);
    chk(r_sts == 0 && r_slot == 0 && g_uown == 8'h55, "R5 stolen slot0", int'(r_slot), 0);
    do_req(3'd1, 8'h11, '0);
    chk(r_sts == 5, "R5 old owner lost slot", int'(r_sts), 5);
  endtask

  task automatic t_full;
    flip_pending = 1'b1;
    do_req(3'd0, 8'h66, '0);
    chk(r_sts == 1 && !g_upd, "R6 retry with flip", int'(r_sts), 1);
    flip_pending = 1'b0;
    do_req(3'd0, 8'h66, '0);
    chk(r_sts == 2 && !g_upd, "R6 deadlock", int'(r_sts), 2);
  endtask

  task automatic t_remove;
    do_req(3'd2, 8'h22, '0);
    chk(r_sts == 3 && !g_upd, "R7 remove pinned busy", int'(r_sts), 3);
    do_req(3'd1, 8'h22, '0);
    do_req(3'd2, 8'h22, '0);
    chk(g_rev && g_rown == 8'h22 && g_upd && !g_en && g_uslot == 1 && r_sts == 0,
        "R7 remove clears slot1", int'(g_uslot), 1);
    do_req(3'd2, 8'h22, '0);
    chk(r_sts == 0 && !g_upd, "R7 remove without slot", int'(g_upd), 0);
  endtask

  task automatic t_reserve;
    do_req(3'd3, 8'h00, '0);
    chk(r_sts == 4, "R8 nospc with one free", int'(r_sts), 4);
    do_req(3'd1, 8'h33, '0);
    do_req(3'd3, 8'h00, '0);
    chk(r_sts == 0 && r_slot == 1 && !g_upd, "R8 reserve slot1", int'(r_slot), 1);
    do_req(3'd0, 8'h77, '0);
    chk(r_slot == 2 && g_rev && g_rown == 8'h33, "R8 reserved slot skipped", int'(r_slot), 2);
    do_req(3'd4, 8'h00, 2'd1);
    chk(r_sts == 0, "R9 unreserve", int'(r_sts), 0);
    do_req(3'd4, 8'h00, 2'd1);
    chk(r_sts == 5, "R9 unreserve twice", int'(r_sts), 5);
    do_req(3'd0, 8'h88, '0);
    chk(r_slot == 1 && !g_rev, "R9 released slot reused", int'(r_slot), 1);
  endtask

  task automatic t_fault_hold;
    do_req(3'd1, 8'h44, '0);
    ack_err = 1'b1;
    do_req(3'd0, 8'h9a, '0);
    ack_err = 1'b0;
    chk(r_sts == 6 && g_rev && g_rown == 8'h44, "R10 fault on update", int'(r_sts), 6);
    ack_wait = 3;
    do_req(3'd0, 8'haa, '0);
    ack_wait = 0;
    chk(r_sts == 0 && r_slot == 3 && !g_rev, "R10 pin released after fault", int'(r_slot), 3);
    chk(g_hold_ok, "R12 update held while waiting", int'(g_hold_ok), 1);
  endtask

  task automatic t_reserve_bound;
    do_req(3'd1, 8'h55, '0);
    do_req(3'd1, 8'haa, '0);
    do_req(3'd3, 8'h00, '0);
    chk(g_rev && g_rown == 8'h55 && g_upd && !g_en && r_sts == 0 && r_slot == 0,
        "R8 reserve bound slot", int'(r_slot), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_pins();
    t_hit_unpin();
    t_dirty();
    t_steal();
    t_full();
    t_remove();
    t_reserve();
    t_fault_hold();
    t_reserve_bound();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule